// File: doc/BRIEF.md
# Program/Erase Status Tracker with Erase Suspend

This block follows the life of an on-chip program or erase engine and publishes the result as one status byte that a host can read. A separate sequencer reports when an operation starts, when it ends, whether it failed, and when it has come to rest after a pause request. A command decoder forwards host commands here. In return it receives a mask of the command codes that the current state allows. Every command code outside that mask is dropped here.

The result of a failed operation stays in the status byte until software clears it. While that result is visible, the tracker refuses new work. Suspending an erase takes two steps. The pause is requested first, and the engine then confirms that it has stopped. After the pause the erase can be resumed or abandoned. Host status reads go through a chip-enable/output-enable strobe pair. The strobes are brought into the system clock, and the byte is frozen at the start of each read cycle.

Top module: `pe_status_tracker`

## Requirements
- R1: The status byte is {ready, suspended, erase-failed, program-failed, protect, 3'b000}, with bit 7 = ready (1 ready, 0 busy). After reset it reads 8'h80 when the protect input is low.
- R2: Bit 3 always equals the protect input and bits 2..0 are always 0. A Clear Status command does not change bit 3.
- R3: A start pulse (accepted when idle) clears bit 7. A done pulse sets bit 7 again. A done pulse together with fail sets bit 5 for an erase kind (1 sector, 2 chip) or bit 4 for a program kind (0). Bits 5 and 4 then hold until a Clear Status command (code 8) is taken.
- R4: While bit 5 or bit 4 is set, mask bits 3 (program), 4 (sector erase) and 5 (chip erase) are 0. A sequencer start pulse is ignored and bit 7 stays 1.
- R5: Suspend (code 6) is taken only while an erase is running. It sets bit 6 and raises seq_pause on the next cycle, while bit 7 stays 0. Bit 7 becomes 1 on the cycle after seq_parked. During a program run, a suspend code changes nothing.
- R6: While bit 6 is set, the mask allows only codes 0 (read array), 1 (read status), 7 (resume) and 9 (abort). Abort is allowed only after the park report. Any other code leaves the status and the sequencer outputs unchanged.
- R7: Resume (code 7) during a suspend clears bit 6 and bit 7 and drops seq_pause. At any other time, resume changes nothing.
- R8: Abort (code 9) during a parked suspend sets bit 7, clears bit 6, drops seq_pause, pulses seq_cancel for exactly one cycle, and leaves bits 5 and 4 as they were.
- R9: The status byte is captured when both strobes have become low, SYNC_STAGES+1 clock edges after the later of the two falling edges. The captured byte stays on rd_data for the rest of that read, and only a new strobe shows a newer value.
- R10: During a read in word mode, the upper byte is driven as 00h (rd_oe all ones). In byte mode, rd_oe for the upper byte is 0. With either strobe high, rd_oe is 0.
- R11: In the idle state the mask is 10'h13F (codes 0..5 and 8). While busy and not suspended, the mask is code 1 only, plus code 6 when the running operation is an erase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Decoder presents a command this cycle |
| cmd_code | input | 4 | Command code (0 read array, 1 read status, 2 read id, 3 program, 4 sector erase, 5 chip erase, 6 suspend, 7 resume, 8 clear, 9 abort) |
| seq_start | input | 1 | Sequencer began an operation |
| seq_kind | input | 2 | Kind of the started operation (0 program, 1 sector erase, 2 chip erase) |
| seq_done | input | 1 | Sequencer finished the operation |
| seq_fail | input | 1 | Qualifies seq_done as a failure |
| seq_parked | input | 1 | Sequencer reached the paused state |
| prot_in | input | 1 | A sector is protected |
| ce_n | input | 1 | Chip-enable strobe, asynchronous, active low |
| oe_n | input | 1 | Output-enable strobe, asynchronous, active low |
| wide_mode | input | 1 | 1 = 16-bit read bus, 0 = 8-bit |
| status_live | output | 8 | Current status byte |
| rd_data | output | DATA_W | Captured status on the read bus |
| rd_oe | output | DATA_W | Per-line drive enable for rd_data |
| seq_pause | output | 1 | Asks the sequencer to pause the erase |
| seq_cancel | output | 1 | One-cycle pulse ending a paused erase |
| accept_mask | output | 10 | One bit per command code that is accepted now |

## Verification
On every cycle the assertions check that the failure bits only fall after a clear command, that the program and erase codes are masked while a failure is shown, that the mask stays restricted during a suspend, that the ready bit returns inside a suspend only after a park report, that the read byte holds steady through a read, and that the cancel pulse lasts a single cycle. Only the bench scenarios can show the ordered handshakes: a suspend followed by park and resume, an abort after park, a suspend code ignored during a program, a resume with nothing to resume, and the exact capture latency of a strobe with the new status hidden until a new strobe.

// File: rtl/pes_pkg.sv
package pes_pkg;

    localparam int CMD_W = 4;
    localparam int NCMD  = 10;

    typedef enum logic [CMD_W-1:0] {
        CMD_RD_ARRAY   = 4'd0,
        CMD_RD_STATUS  = 4'd1,
        CMD_RD_ID      = 4'd2,
        CMD_PROGRAM    = 4'd3,
        CMD_SEC_ERASE  = 4'd4,
        CMD_CHIP_ERASE = 4'd5,
        CMD_SUSPEND    = 4'd6,
        CMD_RESUME     = 4'd7,
        CMD_CLEAR      = 4'd8,
        CMD_ABORT      = 4'd9
    } cmd_e;

    typedef enum logic [1:0] {
        OP_PROGRAM    = 2'd0,
        OP_SEC_ERASE  = 2'd1,
        OP_CHIP_ERASE = 2'd2,
        OP_SPARE      = 2'd3
    } op_e;

    // status byte bit positions (host software decodes these)
    localparam int ST_READY = 7;
    localparam int ST_SUSP  = 6;
    localparam int ST_EFAIL = 5;
    localparam int ST_PFAIL = 4;
    localparam int ST_PROT  = 3;

    typedef struct packed {
        logic ready;
        logic susp;
        logic efail;
        logic pfail;
        logic erase_op;
        logic parked;
        logic cancel;
    } trk_t;

endpackage

// File: rtl/pes_strobe_sync.sv
module pes_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    output logic sel,
    output logic sel_rise
);

    typedef struct packed {
        logic [STAGES-1:0] ce;
        logic [STAGES-1:0] oe;
        logic              sel;
    } sync_t;

    localparam sync_t SY_RST = '{ce: '1, oe: '1, sel: 1'b0};

    sync_t sy_d, sy_q;
    logic  sel_now;

    always_comb begin
        sy_d      = sy_q;
        sy_d.ce[0] = ce_n;
        sy_d.oe[0] = oe_n;
        for (int i = 1; i < STAGES; i++) begin
            sy_d.ce[i] = sy_q.ce[i-1];
            sy_d.oe[i] = sy_q.oe[i-1];
        end
        sel_now  = !sy_q.ce[STAGES-1] && !sy_q.oe[STAGES-1];
        sy_d.sel = sel_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sy_q <= SY_RST;
        else        sy_q <= sy_d;
    end

    assign sel      = sel_now;
    assign sel_rise = sel_now && !sy_q.sel;

endmodule

// File: rtl/pes_op_tracker.sv
module pes_op_tracker
    import pes_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic             seq_start,
    input  logic [1:0]       seq_kind,
    input  logic             seq_done,
    input  logic             seq_fail,
    input  logic             seq_parked,
    output logic             st_ready,
    output logic             st_susp,
    output logic             st_efail,
    output logic             st_pfail,
    output logic             seq_pause,
    output logic             seq_cancel,
    output logic [NCMD-1:0]  accept_mask
);

    localparam trk_t TRK_RST = '{ready: 1'b1, default: 1'b0};

    trk_t            trk_d, trk_q;
    logic [NCMD-1:0] mask_c;
    logic [NCMD-1:0] dec_c;
    logic [NCMD-1:0] take_c;
    logic            fail_any;

    // which command codes the present state admits
    always_comb begin
        mask_c   = '0;
        fail_any = trk_q.efail || trk_q.pfail;
        if (trk_q.susp) begin
            mask_c[int'(CMD_RD_ARRAY)]  = 1'b1;
            mask_c[int'(CMD_RD_STATUS)] = 1'b1;
            mask_c[int'(CMD_RESUME)]    = 1'b1;
            mask_c[int'(CMD_ABORT)]     = trk_q.parked;
        end else if (!trk_q.ready) begin
            mask_c[int'(CMD_RD_STATUS)] = 1'b1;
            mask_c[int'(CMD_SUSPEND)]   = trk_q.erase_op;
        end else begin
            mask_c[int'(CMD_RD_ARRAY)]   = 1'b1;
            mask_c[int'(CMD_RD_STATUS)]  = 1'b1;
            mask_c[int'(CMD_RD_ID)]      = 1'b1;
            mask_c[int'(CMD_CLEAR)]      = 1'b1;
            mask_c[int'(CMD_PROGRAM)]    = !fail_any;
            mask_c[int'(CMD_SEC_ERASE)]  = !fail_any;
            mask_c[int'(CMD_CHIP_ERASE)] = !fail_any;
        end
    end

    // one-hot decode of the presented code, gated by the mask
    always_comb begin
        for (int i = 0; i < NCMD; i++) begin
            dec_c[i] = (cmd_code == CMD_W'(i));
        end
        take_c = cmd_valid ? (dec_c & mask_c) : '0;
    end

    always_comb begin
        trk_d        = trk_q;
        trk_d.cancel = 1'b0;

        // sequencer reports
        if (seq_done && !trk_q.ready && !trk_q.susp) begin
            trk_d.ready = 1'b1;
            if (seq_fail) begin
                if (trk_q.erase_op) trk_d.efail = 1'b1;
                else                trk_d.pfail = 1'b1;
            end
        end
        if (seq_parked && trk_q.susp && !trk_q.parked) begin
            trk_d.ready  = 1'b1;
            trk_d.parked = 1'b1;
        end
        if (seq_start && trk_q.ready && !trk_q.susp && !fail_any) begin
            trk_d.ready    = 1'b0;
            trk_d.erase_op = (seq_kind != OP_PROGRAM);
        end

        // host commands (take precedence on a collision)
        if (take_c[int'(CMD_SUSPEND)]) begin
            trk_d.susp = 1'b1;
        end
        if (take_c[int'(CMD_RESUME)]) begin
            trk_d.susp   = 1'b0;
            trk_d.parked = 1'b0;
            trk_d.ready  = 1'b0;
        end
        if (take_c[int'(CMD_CLEAR)]) begin
            trk_d.efail = 1'b0;
            trk_d.pfail = 1'b0;
        end
        if (take_c[int'(CMD_ABORT)]) begin
            trk_d.susp     = 1'b0;
            trk_d.parked   = 1'b0;
            trk_d.ready    = 1'b1;
            trk_d.erase_op = 1'b0;
            trk_d.cancel   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= TRK_RST;
        else        trk_q <= trk_d;
    end

    assign st_ready    = trk_q.ready;
    assign st_susp     = trk_q.susp;
    assign st_efail    = trk_q.efail;
    assign st_pfail    = trk_q.pfail;
    assign seq_pause   = trk_q.susp;
    assign seq_cancel  = trk_q.cancel;
    assign accept_mask = mask_c;

endmodule

// File: rtl/pes_read_port.sv
module pes_read_port #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sel_rise,
    input  logic [7:0]        status_now,
    input  logic              wide_mode,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] rd_oe
);

    localparam int HI_W = DATA_W - 8;

    typedef struct packed {
        logic       drive;
        logic [7:0] snap;
    } rdp_t;

    localparam rdp_t RDP_RST = '{drive: 1'b0, snap: 8'h00};

    rdp_t rdp_d, rdp_q;

    always_comb begin
        rdp_d = rdp_q;
        if (sel_rise) begin
            rdp_d.drive = 1'b1;
            rdp_d.snap  = status_now;
        end else if (!sel) begin
            rdp_d.drive = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdp_q <= RDP_RST;
        else        rdp_q <= rdp_d;
    end

    assign rd_data = {{HI_W{1'b0}}, (rdp_q.drive ? rdp_q.snap : 8'h00)};
    assign rd_oe   = {{HI_W{rdp_q.drive && wide_mode}}, {8{rdp_q.drive}}};

endmodule

// File: rtl/pe_status_tracker.sv
module pe_status_tracker
    import pes_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_code,
    input  logic              seq_start,
    input  logic [1:0]        seq_kind,
    input  logic              seq_done,
    input  logic              seq_fail,
    input  logic              seq_parked,
    input  logic              prot_in,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              wide_mode,
    output logic [7:0]        status_live,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] rd_oe,
    output logic              seq_pause,
    output logic              seq_cancel,
    output logic [9:0]        accept_mask
);

    logic st_ready, st_susp, st_efail, st_pfail;
    logic sel, sel_rise;

    pes_op_tracker u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .seq_start   (seq_start),
        .seq_kind    (seq_kind),
        .seq_done    (seq_done),
        .seq_fail    (seq_fail),
        .seq_parked  (seq_parked),
        .st_ready    (st_ready),
        .st_susp     (st_susp),
        .st_efail    (st_efail),
        .st_pfail    (st_pfail),
        .seq_pause   (seq_pause),
        .seq_cancel  (seq_cancel),
        .accept_mask (accept_mask)
    );

    always_comb begin
        status_live           = 8'h00;
        status_live[ST_READY] = st_ready;
        status_live[ST_SUSP]  = st_susp;
        status_live[ST_EFAIL] = st_efail;
        status_live[ST_PFAIL] = st_pfail;
        status_live[ST_PROT]  = prot_in;
    end

    pes_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .sel      (sel),
        .sel_rise (sel_rise)
    );

    pes_read_port #(.DATA_W(DATA_W)) u_rdp (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .sel_rise   (sel_rise),
        .status_now (status_live),
        .wide_mode  (wide_mode),
        .rd_data    (rd_data),
        .rd_oe      (rd_oe)
    );

endmodule

// File: rtl/pes_checker.sv
module pes_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [3:0]        cmd_code,
    input logic              seq_parked,
    input logic              prot_in,
    input logic              wide_mode,
    input logic [7:0]        status_live,
    input logic [7:0]        rd_lo,
    input logic [DATA_W-1:0] rd_oe,
    input logic              seq_cancel,
    input logic [9:0]        accept_mask
);

    AST_FAIL_CLEARED_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(status_live[5]) || $fell(status_live[4])) |-> $past(cmd_valid && cmd_code == 4'd8)); // R3

    AST_PROT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (status_live[3] == prot_in) && (status_live[2:0] == 3'b000)); // R2

    AST_NO_START_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (status_live[5] || status_live[4]) |-> (accept_mask[5:3] == 3'b000)); // R4

    AST_FAIL_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_live[7] && (status_live[5] || status_live[4])) |=> status_live[7]); // R4

    AST_SUSP_ENTRY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_live[6]) |-> $past(!status_live[7])); // R5

    AST_PARK_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status_live[7]) && status_live[6]) |-> $past(seq_parked)); // R5

    AST_SUSP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        status_live[6] |-> ((accept_mask & ~10'b1010000011) == 10'b0)); // R6

    AST_CANCEL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_cancel |=> !seq_cancel); // R8

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe[0] && $past(rd_oe[0])) |-> $stable(rd_lo)); // R9

    AST_BYTE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |-> (rd_oe[DATA_W-1:8] == '0)); // R10

endmodule

bind pe_status_tracker pes_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .seq_parked  (seq_parked),
    .prot_in     (prot_in),
    .wide_mode   (wide_mode),
    .status_live (status_live),
    .rd_lo       (rd_data[7:0]),
    .rd_oe       (rd_oe),
    .seq_cancel  (seq_cancel),
    .accept_mask (accept_mask)
);

// File: tb/tb_pe_status_tracker.sv
module tb_pe_status_tracker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, seq_start, seq_done, seq_fail, seq_parked;
    logic [3:0]  cmd_code;
    logic [1:0]  seq_kind;
    logic        prot_in, ce_n, oe_n, wide_mode;
    logic [7:0]  status_live;
    logic [15:0] rd_data, rd_oe;
    logic        seq_pause, seq_cancel;
    logic [9:0]  accept_mask;

    int    checks = 0;
    int    errors = 0;
    bit    cmp_en = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    pe_status_tracker dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .seq_start(seq_start), .seq_kind(seq_kind), .seq_done(seq_done),
        .seq_fail(seq_fail), .seq_parked(seq_parked), .prot_in(prot_in),
        .ce_n(ce_n), .oe_n(oe_n), .wide_mode(wide_mode),
        .status_live(status_live), .rd_data(rd_data), .rd_oe(rd_oe),
        .seq_pause(seq_pause), .seq_cancel(seq_cancel), .accept_mask(accept_mask)
    );

    // ---------------- behavioural reference model ----------------
    bit m_rdy, m_sus, m_ef, m_pf, m_er, m_park, m_can, m_selp, m_drv;
    bit [7:0] m_snap;
    bit ce_hist[$];
    bit oe_hist[$];

    function automatic bit [7:0] m_status();
        return {m_rdy, m_sus, m_ef, m_pf, prot_in, 3'b000};
    endfunction

    function automatic bit [9:0] m_mask();
        bit [9:0] m = '0;
        if (m_sus)
            m = 10'b0010000011 | (m_park ? 10'b1000000000 : 10'b0);
        else if (!m_rdy)
            m = 10'b0000000010 | (m_er ? 10'b0001000000 : 10'b0);
        else
            m = (m_ef || m_pf) ? 10'b0100000111 : 10'b0100111111;
        return m;
    endfunction

    always @(posedge clk) begin : model
        bit sel;
        bit [9:0] msk;
        bit took;
        if (!rst_n) begin
            m_rdy = 1; m_sus = 0; m_ef = 0; m_pf = 0; m_er = 0; m_park = 0; m_can = 0;
            m_selp = 0; m_drv = 0; m_snap = 0;
            ce_hist = '{1'b1, 1'b1};
            oe_hist = '{1'b1, 1'b1};
        end else begin
            sel = !ce_hist[0] && !oe_hist[0];
            if (sel && !m_selp) begin m_snap = m_status(); m_drv = 1; end
            else if (!sel) m_drv = 0;
            m_selp = sel;
            void'(ce_hist.pop_front()); ce_hist.push_back(ce_n);
            void'(oe_hist.pop_front()); oe_hist.push_back(oe_n);

            msk  = m_mask();
            took = cmd_valid && (cmd_code < 4'd10) && msk[cmd_code];
            m_can = 0;
            if (seq_done && !m_rdy && !m_sus) begin
                m_rdy = 1;
                if (seq_fail) begin if (m_er) m_ef = 1; else m_pf = 1; end
            end
            if (seq_parked && m_sus && !m_park) begin m_rdy = 1; m_park = 1; end
            if (seq_start && m_rdy && !m_sus && !m_ef && !m_pf) begin
                m_rdy = 0; m_er = (seq_kind != 2'd0);
            end
            if (took) begin
                case (cmd_code)
                    4'd6: m_sus = 1;
                    4'd7: begin m_sus = 0; m_park = 0; m_rdy = 0; end
                    4'd8: begin m_ef = 0; m_pf = 0; end
                    4'd9: begin m_sus = 0; m_park = 0; m_rdy = 1; m_er = 0; m_can = 1; end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison, well after the edge
    initial forever begin
        @(posedge clk);
        #15;
        if (cmp_en && !finished) begin
            chk(cur_req, "status_live", {8'h00, status_live}, {8'h00, m_status()});
            chk(cur_req, "accept_mask", {6'h00, accept_mask}, {6'h00, m_mask()});
            chk(cur_req, "seq_pause", {15'h0, seq_pause}, {15'h0, m_sus});
            chk(cur_req, "seq_cancel", {15'h0, seq_cancel}, {15'h0, m_can});
            chk(cur_req, "rd_data", rd_data, m_drv ? {8'h00, m_snap} : 16'h0000);
            chk(cur_req, "rd_oe", rd_oe, m_drv ? (wide_mode ? 16'hFFFF : 16'h00FF) : 16'h0000);
        end
    end

    // ---------------- stimulus helpers (stub sequencer + decoder) ----------------
    task automatic send_cmd(logic [3:0] c);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic seq_begin(logic [1:0] k);
        @(negedge clk); seq_start = 1'b1; seq_kind = k;
        @(negedge clk); seq_start = 1'b0;
    endtask

    task automatic seq_end(bit f);
        @(negedge clk); seq_done = 1'b1; seq_fail = f;
        @(negedge clk); seq_done = 1'b0; seq_fail = 1'b0;
    endtask

    task automatic seq_park();
        @(negedge clk); seq_parked = 1'b1;
        @(negedge clk); seq_parked = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; cmd_valid = 0; cmd_code = 0; seq_start = 0; seq_kind = 0;
        seq_done = 0; seq_fail = 0; seq_parked = 0; prot_in = 0;
        ce_n = 1; oe_n = 1; wide_mode = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cmp_en = 1;

        cur_req = "R1";
        chk("R1", "reset status", {8'h00, status_live}, 16'h0080);
        chk("R11", "idle mask", {6'h00, accept_mask}, 16'h013F);

        cur_req = "R2";
        prot_in = 1; @(negedge clk);
        chk("R2", "protect shown", {8'h00, status_live}, 16'h0088);
        send_cmd(4'd8);
        chk("R2", "protect kept after clear", {8'h00, status_live}, 16'h0088);
        prot_in = 0; @(negedge clk);

        cur_req = "R3";
        seq_begin(2'd0);
        chk("R3", "busy after start", {8'h00, status_live}, 16'h0000);
        chk("R11", "busy program mask", {6'h00, accept_mask}, 16'h0002);
        cur_req = "R5";
        send_cmd(4'd6);
        chk("R5", "suspend during program ignored", {8'h00, status_live}, 16'h0000);
        chk("R5", "no pause during program", {15'h0, seq_pause}, 16'h0000);
        seq_end(0);
        chk("R3", "ready after done", {8'h00, status_live}, 16'h0080);

        cur_req = "R3";
        seq_begin(2'd0);
        seq_end(1);
        chk("R3", "program fail bit", {8'h00, status_live}, 16'h0090);
        cur_req = "R4";
        chk("R4", "launch codes masked", {13'h0, accept_mask[5:3]}, 16'h0000);
        seq_begin(2'd1);
        chk("R4", "start refused on fail", {8'h00, status_live}, 16'h0090);
        repeat (5) @(negedge clk);
        chk("R3", "fail bit sticky", {8'h00, status_live}, 16'h0090);
        send_cmd(4'd8);
        chk("R3", "clear drops fail", {8'h00, status_live}, 16'h0080);

        cur_req = "R3";
        seq_begin(2'd2);
        seq_end(1);
        chk("R3", "chip erase fail bit", {8'h00, status_live}, 16'h00A0);
        send_cmd(4'd8);

        cur_req = "R5";
        seq_begin(2'd1);
        chk("R11", "busy erase mask", {6'h00, accept_mask}, 16'h0042);
        send_cmd(4'd9);
        send_cmd(4'd6);
        chk("R5", "suspend pending", {8'h00, status_live}, 16'h0040);
        chk("R5", "pause raised", {15'h0, seq_pause}, 16'h0001);
        chk("R8", "abort before park masked", {15'h0, accept_mask[9]}, 16'h0000);
        repeat (2) @(negedge clk);
        chk("R5", "busy until parked", {8'h00, status_live}, 16'h0040);
        seq_park();
        chk("R5", "ready when parked", {8'h00, status_live}, 16'h00C0);
        cur_req = "R6";
        chk("R6", "suspended mask", {6'h00, accept_mask}, 16'h0283);
        send_cmd(4'd2);
        send_cmd(4'd6);
        send_cmd(4'd3);
        send_cmd(4'd8);
        chk("R6", "other codes ignored", {8'h00, status_live}, 16'h00C0);
        cur_req = "R7";
        send_cmd(4'd7);
        chk("R7", "resume clears suspend", {8'h00, status_live}, 16'h0000);
        chk("R7", "pause dropped", {15'h0, seq_pause}, 16'h0000);
        send_cmd(4'd7);
        chk("R7", "resume while running ignored", {8'h00, status_live}, 16'h0000);
        seq_end(0);
        send_cmd(4'd7);
        chk("R7", "resume when idle ignored", {8'h00, status_live}, 16'h0080);

        cur_req = "R8";
        seq_begin(2'd2);
        send_cmd(4'd6);
        seq_park();
        send_cmd(4'd9);
        chk("R8", "abort status", {8'h00, status_live}, 16'h0080);
        chk("R8", "cancel pulse", {15'h0, seq_cancel}, 16'h0001);
        chk("R8", "pause dropped", {15'h0, seq_pause}, 16'h0000);
        @(negedge clk);
        chk("R8", "cancel one cycle", {15'h0, seq_cancel}, 16'h0000);

        cur_req = "R9";
        seq_begin(2'd0);
        @(negedge clk); ce_n = 0;
        repeat (2) @(negedge clk);
        oe_n = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R9", "not yet driven", rd_oe, 16'h0000);
        @(negedge clk);
        chk("R9", "driven after sync", rd_oe, 16'hFFFF);
        chk("R10", "word read data", rd_data, 16'h0000);
        seq_end(0);
        repeat (2) @(negedge clk);
        chk("R9", "snapshot held", rd_data, 16'h0000);
        oe_n = 1;
        repeat (4) @(negedge clk);
        cur_req = "R10";
        chk("R10", "released bus", rd_oe, 16'h0000);
        cur_req = "R9";
        oe_n = 0;
        repeat (4) @(negedge clk);
        chk("R9", "new strobe new value", rd_data, 16'h0080);
        cur_req = "R10";
        wide_mode = 0; #1;
        chk("R10", "byte mode upper float", rd_oe, 16'h00FF);
        @(negedge clk);
        wide_mode = 1; #1;
        chk("R10", "word mode upper driven", rd_oe, 16'hFFFF);
        @(negedge clk);
        ce_n = 1; oe_n = 1;
        repeat (5) @(negedge clk);
        chk("R10", "deselected", rd_oe, 16'h0000);

        cmp_en = 0;
        finish_run();
    end

endmodule